// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that fall inside a graphics aperture window onto physical memory pages. The mapping lives in system memory as two levels of tables. A page directory is indexed by the top ten bits of the bus address, and each valid directory slot points at a 4 KiB leaf table. That leaf table holds 1024 32-bit page entries indexed by the next ten bits. A small fully associative cache keeps recent page translations, so a repeated page is answered without touching memory.

Software programs the block through a small register port. It sets the aperture size and the window base, switches the two enable controls on, points the block at the directory, and invalidates the whole cache with a single write. A client presents one bus address at a time and receives either a physical address or a fault. Addresses outside the window, or any address while translation is switched off, come back unchanged. On a cache miss the block walks the tables through a memory read port that has one read outstanding at a time.

Top module: `aperture_xlate`

## Requirements
- R1: After reset every register reads 0, translation is off, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The register map, selected by `reg_addr`, is as follows:
  - 0 is the size register. It keeps bits 3:0: bit 0 switches the aperture on, and bits 3:1 hold the size field.
  - 1 is the control register. It keeps bit 2, which switches translation on.
  - 2 is the directory base. It keeps bits 31:12.
  - 3 is the flush register. It always reads 0.
  - 4 is the window base. It keeps bits 31:25.
  - All other bits read 0.
- R3: When size bit 0 or control bit 2 is clear, an accepted request is answered in the next cycle with the same address, no fault and no memory read.
- R4: A size field value k from 0 to 6 (register encodings 0x0, 0x2, 0x4, 0x6, 0x8, 0xA, 0xC) gives a window of 32 MiB shifted left by k, from 32 MiB up to 2048 MiB. The field value 7 acts as 2048 MiB. An address is inside the window when it equals the window base in every bit above the window size. An address outside the window passes through unchanged.
- R5: On a miss the block makes two reads:
  - First the directory slot at {dirbase[31:12], a[31:22], 2'b00}.
  - Then the leaf entry at {slot[31:12], a[21:12], 2'b00}.
  - The result is {leaf[31:12], a[11:0]} with no fault.
- R6: A directory slot with bit 0 clear ends the walk after one read with a fault, and `rsp_addr` is 0.
- R7: A leaf entry with bit 0 clear gives a fault after two reads. A faulting walk fills no cache entry.
- R8: A request to a cached page, at any offset, is answered in the next cycle with no memory read.
- R9: Cache entries are replaced in round-robin order over `CACHE_ENTRIES` slots.
- R10: Writing the flush register with bit 0 set invalidates every cached translation at once. Writing it with bit 0 clear has no effect.
- R11: A flush during a walk still lets that walk's response be delivered, but the walk fills no cache entry.
- R12: Only one request is outstanding at a time:
  - `req_ready` is low while a walk is in progress.
  - `mem_req` and `mem_addr` hold steady until `mem_ack`.
  - Each accepted request yields exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Physical or passed-through address, 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read address |
| mem_ack | input | 1 | Read data valid, ends the read |
| mem_data | input | 32 | Table read data |

## Verification
The bench builds the block with `CACHE_ENTRIES` set to 4. At that size, filling the cache, wrapping the round-robin pointer and evicting a live entry take only a few misses. A memory responder with a fixed latency serves the tables. Several size fields move the window edge, and flushes are placed both between requests and in the middle of a walk.

// File: rtl/axl_pkg.sv
package axl_pkg;

  localparam int unsigned VA_W    = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned PG_W    = VA_W - OFF_W;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned WBASE_W = 7;

  localparam logic [2:0] RA_SIZE  = 3'd0;
  localparam logic [2:0] RA_CTRL  = 3'd1;
  localparam logic [2:0] RA_DIRB  = 3'd2;
  localparam logic [2:0] RA_FLUSH = 3'd3;
  localparam logic [2:0] RA_WBASE = 3'd4;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_DIR  = 2'd1,
    WK_LEAF = 2'd2
  } walk_state_e;

  // High-bit mask of the window for a size field value; 7 behaves as 6.
  function automatic logic [VA_W-1:0] win_mask(input logic [2:0] field);
    logic [2:0]      k;
    logic [VA_W-1:0] span;
    k    = (field == 3'd7) ? 3'd6 : field;
    span = 32'h0200_0000 << k;
    return ~(span - 32'd1);
  endfunction

endpackage

// File: rtl/axl_regs.sv
module axl_regs
  import axl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [2:0]         size_field,
  output logic               aper_on,
  output logic               xlate_on,
  output logic [PG_W-1:0]    dir_base,
  output logic [WBASE_W-1:0] win_base,
  output logic               flush_pulse
);

  logic [3:0]         size_q, size_d;
  logic               ctrl_q, ctrl_d;
  logic [PG_W-1:0]    dirb_q, dirb_d;
  logic [WBASE_W-1:0] wb_q, wb_d;
  logic               unused_wbits;

  assign unused_wbits = ^wdata[11:4];

  always_comb begin
    size_d = size_q;
    ctrl_d = ctrl_q;
    dirb_d = dirb_q;
    wb_d   = wb_q;
    if (wr) begin
      case (addr)
        RA_SIZE:  size_d = wdata[3:0];
        RA_CTRL:  ctrl_d = wdata[2];
        RA_DIRB:  dirb_d = wdata[31:12];
        RA_WBASE: wb_d   = wdata[31:25];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      ctrl_q <= 1'b0;
      dirb_q <= '0;
      wb_q   <= '0;
    end else if (wr) begin
      size_q <= size_d;
      ctrl_q <= ctrl_d;
      dirb_q <= dirb_d;
      wb_q   <= wb_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_SIZE:  rdata = {28'd0, size_q};
      RA_CTRL:  rdata = {29'd0, ctrl_q, 2'b00};
      RA_DIRB:  rdata = {dirb_q, 12'd0};
      RA_WBASE: rdata = {wb_q, 25'd0};
      default:  rdata = '0;
    endcase
  end

  assign flush_pulse = wr && (addr == RA_FLUSH) && wdata[0];
  assign size_field  = size_q[3:1];
  assign aper_on     = size_q[0];
  assign xlate_on    = ctrl_q;
  assign dir_base    = dirb_q;
  assign win_base    = wb_q;

endmodule

// File: rtl/axl_tcache.sv
module axl_tcache
  import axl_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PG_W-1:0] lk_tag,
  output logic            lk_hit,
  output logic [PG_W-1:0] lk_page,
  input  logic            fill_en,
  input  logic [PG_W-1:0] fill_tag,
  input  logic [PG_W-1:0] fill_page,
  input  logic            flush
);

  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [PG_W-1:0]    tag_q  [ENTRIES];
  logic [PG_W-1:0]    page_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic ent_we;
    assign ent_we   = fill_en && (ptr_q == PTR_W'(i));
    assign match[i] = vld_q[i] && (tag_q[i] == lk_tag);

    always_comb begin
      if (flush)       vld_d[i] = 1'b0;
      else if (ent_we) vld_d[i] = 1'b1;
      else             vld_d[i] = vld_q[i];
    end

    always_ff @(posedge clk) begin
      if (ent_we) begin
        tag_q[i]  <= fill_tag;
        page_q[i] <= fill_page;
      end
    end
  end

  always_comb begin
    lk_page = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (match[j]) lk_page = lk_page | page_q[j];
    end
  end

  assign lk_hit = |match;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (fill_en) ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/axl_walker.sv
module axl_walker
  import axl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_addr,
  input  logic               xl_on,
  input  logic [VA_W-1:0]    wmask,
  input  logic [WBASE_W-1:0] win_base,
  input  logic [PG_W-1:0]    dir_base,
  input  logic               lk_hit,
  input  logic [PG_W-1:0]    lk_page,
  input  logic               flush,
  output logic               mem_req,
  output logic [VA_W-1:0]    mem_addr,
  input  logic               mem_ack,
  input  logic [31:0]        mem_data,
  output logic               fill_en,
  output logic [PG_W-1:0]    fill_tag,
  output logic [PG_W-1:0]    fill_page,
  output logic               rsp_valid,
  output logic [VA_W-1:0]    rsp_addr,
  output logic               rsp_fault
);

  walk_state_e       st_q, st_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic [PG_W-1:0]   slot_q, slot_d;
  logic              disc_q, disc_d;
  logic              rv_q, rv_d;
  logic [VA_W-1:0]   ra_q, ra_d;
  logic              rf_q, rf_d;
  logic              accept, in_win, do_xl, cap_en;
  logic [VA_W-1:0]   wbase_full;
  logic              unused_mbits;

  assign unused_mbits = ^mem_data[11:1];
  assign wbase_full   = {win_base, {(VA_W-WBASE_W){1'b0}}};
  assign req_ready    = (st_q == WK_IDLE);
  assign accept       = req_valid && req_ready;
  assign in_win       = ((req_addr ^ wbase_full) & wmask) == '0;
  assign do_xl        = xl_on && in_win;

  always_comb begin
    st_d    = st_q;
    va_d    = va_q;
    slot_d  = slot_q;
    disc_d  = disc_q || (flush && (st_q != WK_IDLE));
    rv_d    = 1'b0;
    ra_d    = ra_q;
    rf_d    = rf_q;
    fill_en = 1'b0;
    cap_en  = 1'b0;
    case (st_q)
      WK_IDLE: begin
        if (accept) begin
          if (!do_xl) begin
            rv_d = 1'b1;
            ra_d = req_addr;
            rf_d = 1'b0;
          end else if (lk_hit) begin
            rv_d = 1'b1;
            ra_d = {lk_page, req_addr[OFF_W-1:0]};
            rf_d = 1'b0;
          end else begin
            cap_en = 1'b1;
            va_d   = req_addr;
            disc_d = 1'b0;
            st_d   = WK_DIR;
          end
        end
      end
      WK_DIR: begin
        if (mem_ack) begin
          if (mem_data[0]) begin
            slot_d = mem_data[31:12];
            st_d   = WK_LEAF;
          end else begin
            rv_d = 1'b1;
            ra_d = '0;
            rf_d = 1'b1;
            st_d = WK_IDLE;
          end
        end
      end
      WK_LEAF: begin
        if (mem_ack) begin
          rv_d = 1'b1;
          st_d = WK_IDLE;
          if (mem_data[0]) begin
            ra_d    = {mem_data[31:12], va_q[OFF_W-1:0]};
            rf_d    = 1'b0;
            fill_en = !disc_q && !flush;
          end else begin
            ra_d = '0;
            rf_d = 1'b1;
          end
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_comb begin
    if (st_q == WK_DIR) mem_addr = {dir_base, va_q[VA_W-1 -: IDX_W], 2'b00};
    else                mem_addr = {slot_q, va_q[OFF_W+IDX_W-1:OFF_W], 2'b00};
  end

  assign mem_req   = (st_q != WK_IDLE);
  assign fill_tag  = va_q[VA_W-1:OFF_W];
  assign fill_page = mem_data[31:12];
  assign rsp_valid = rv_q;
  assign rsp_addr  = ra_q;
  assign rsp_fault = rf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      disc_q <= 1'b0;
      rv_q   <= 1'b0;
      ra_q   <= '0;
      rf_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      disc_q <= disc_d;
      rv_q   <= rv_d;
      if (rv_d) begin
        ra_q <= ra_d;
        rf_q <= rf_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) va_q <= va_d;
    if (st_q == WK_DIR && mem_ack) slot_q <= slot_d;
  end

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import axl_pkg::*;
#(
  parameter int unsigned CACHE_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_data
);

  logic [2:0]         size_field;
  logic               aper_on, ctrl_on, xl_on, flush_pulse;
  logic [PG_W-1:0]    dir_base;
  logic [WBASE_W-1:0] win_base;
  logic [VA_W-1:0]    wmask;
  logic               cache_hit, fill_en;
  logic [PG_W-1:0]    cache_page, fill_tag, fill_page;

  assign xl_on = aper_on && ctrl_on;
  assign wmask = win_mask(size_field);

  axl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .size_field  (size_field),
    .aper_on     (aper_on),
    .xlate_on    (ctrl_on),
    .dir_base    (dir_base),
    .win_base    (win_base),
    .flush_pulse (flush_pulse)
  );

  axl_tcache #(.ENTRIES(CACHE_ENTRIES)) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (req_addr[VA_W-1:OFF_W]),
    .lk_hit    (cache_hit),
    .lk_page   (cache_page),
    .fill_en   (fill_en),
    .fill_tag  (fill_tag),
    .fill_page (fill_page),
    .flush     (flush_pulse)
  );

  axl_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .xl_on     (xl_on),
    .wmask     (wmask),
    .win_base  (win_base),
    .dir_base  (dir_base),
    .lk_hit    (cache_hit),
    .lk_page   (cache_page),
    .flush     (flush_pulse),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_data  (mem_data),
    .fill_en   (fill_en),
    .fill_tag  (fill_tag),
    .fill_page (fill_page),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault)
  );

endmodule

// File: rtl/aperture_xlate_chk.sv
module aperture_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        xl_on,
  input logic        flush_pulse,
  input logic        cache_hit
);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R12
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xl_on) |=>
      (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr)));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == 32'd0));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> !cache_hit);

  // R8
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xl_on && cache_hit) |=> (rsp_valid && !rsp_fault));

endmodule

bind aperture_xlate aperture_xlate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_addr    (rsp_addr),
  .rsp_fault   (rsp_fault),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .xl_on       (xl_on),
  .flush_pulse (flush_pulse),
  .cache_hit   (cache_hit)
);

// File: tb/aperture_xlate_bench.sv
`timescale 1ns/1ps
module aperture_xlate_bench;

  localparam int ENT = 4;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_data = '0;

  always #10 clk = ~clk;

  aperture_xlate #(.CACHE_ENTRIES(ENT)) u_aperture_xlate (.*);

  int nchk = 0, nfail = 0, rd_count = 0, rsp_seen = 0, mon_bad = 0;
  bit expect_rsp = 0;
  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] rd_log[$];

  // reference model state
  logic [3:0]  m_size;
  bit          m_ctrl;
  logic [19:0] m_dirb;
  logic [6:0]  m_wb;
  logic [19:0] m_tag [ENT];
  bit          m_val [ENT];
  int          m_ptr;

  task automatic check(input bit ok, input string req, input string msg);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [31:0] mrd(input logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'd0;
  endfunction

  // memory responder with fixed latency
  int wcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == LAT) begin
        mem_ack = 1;
        mem_data = mrd(mem_addr);
        rd_count++;
        rd_log.push_back(mem_addr);
      end else wcnt++;
    end
  end

  // per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && req_ready) mon_bad++;
      if (rsp_valid) begin
        rsp_seen++;
        if (!expect_rsp) mon_bad++;
      end
    end
  end

  task automatic model_flush();
    for (int i = 0; i < ENT; i++) m_val[i] = 0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (a)
      3'd0: m_size = d[3:0];
      3'd1: m_ctrl = d[2];
      3'd2: m_dirb = d[31:12];
      3'd3: if (d[0]) model_flush();
      3'd4: m_wb = d[31:25];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, $sformatf("reg %0d read %h expected %h", a, reg_rdata, exp));
  endtask

  task automatic xlate(input logic [31:0] a, input string req, input bit flush_mid);
    logic [31:0] e_addr, d_addr, l_addr, slot, leaf;
    bit e_fault, hit, fill;
    int e_reads, k, cyc, r0, s0;
    longint span;
    bit inwin;
    k = (m_size[3:1] == 3'd7) ? 6 : int'(m_size[3:1]);
    span = 64'h200_0000 << k;
    inwin = ((longint'(a) ^ longint'({m_wb, 25'd0})) & ~(span - 1) & 64'hFFFF_FFFF) == 0;
    hit = 0; fill = 0; e_fault = 0; e_reads = 0;
    d_addr = {m_dirb, a[31:22], 2'b00};
    slot = mrd(d_addr);
    l_addr = {slot[31:12], a[21:12], 2'b00};
    leaf = mrd(l_addr);
    if (!(m_size[0] && m_ctrl && inwin)) e_addr = a;
    else begin
      for (int i = 0; i < ENT; i++) if (m_val[i] && m_tag[i] == a[31:12]) hit = 1;
      if (hit) e_addr = {leaf[31:12], a[11:0]};
      else if (!slot[0]) begin e_fault = 1; e_addr = 0; e_reads = 1; end
      else if (!leaf[0]) begin e_fault = 1; e_addr = 0; e_reads = 2; end
      else begin e_addr = {leaf[31:12], a[11:0]}; e_reads = 2; fill = 1; end
    end
    r0 = rd_count; s0 = rsp_seen; rd_log.delete();
    @(negedge clk);
    check(req_ready == 1'b1, req, $sformatf("req_ready %b expected 1 before %h", req_ready, a));
    req_valid = 1; req_addr = a; expect_rsp = 1;
    @(negedge clk);
    req_valid = 0; cyc = 1;
    if (e_reads > 0)
      check(req_ready == 1'b0, "R12", $sformatf("req_ready %b during walk, expected 0", req_ready));
    if (flush_mid) begin reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'd1; end
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      reg_wr = 0;
      cyc++;
    end
    reg_wr = 0;
    check(rsp_valid && rsp_addr == e_addr && rsp_fault == e_fault, req,
          $sformatf("addr %h: got v%b %h f%b expected %h f%b", a, rsp_valid, rsp_addr, rsp_fault, e_addr, e_fault));
    check(rd_count - r0 == e_reads, req,
          $sformatf("addr %h: %0d reads expected %0d", a, rd_count - r0, e_reads));
    if (e_reads == 0)
      check(cyc == 1, req, $sformatf("addr %h: latency %0d expected 1", a, cyc));
    if (e_reads >= 1 && rd_log.size() >= 1)
      check(rd_log[0] == d_addr, "R5", $sformatf("dir read %h expected %h", rd_log[0], d_addr));
    if (e_reads == 2 && rd_log.size() == 2)
      check(rd_log[1] == l_addr, "R5", $sformatf("leaf read %h expected %h", rd_log[1], l_addr));
    @(negedge clk);
    expect_rsp = 0;
    check(rsp_seen - s0 == 1, "R12", $sformatf("%0d responses expected 1", rsp_seen - s0));
    if (flush_mid) model_flush();
    else if (fill) begin
      m_tag[m_ptr] = a[31:12]; m_val[m_ptr] = 1; m_ptr = (m_ptr + 1) % ENT;
    end
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    m_size = 0; m_ctrl = 0; m_dirb = 0; m_wb = 0; m_ptr = 0; model_flush();
    for (int n = 0; n < 16; n++)
      mem_img[32'h0020_0000 + 4*n] = (n == 9) ? 32'd0 : ((32'h3000_0000 + n*32'h5000) | 32'd1);
    mem_img[32'h0010_0C00] = 32'h0020_0001;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && !rsp_valid && !mem_req, "R1",
          $sformatf("ready %b rsp %b mem %b expected 1 0 0", req_ready, rsp_valid, mem_req));
    rst_n = 1;
    for (int r = 0; r < 5; r++) rd_chk(3'(r), 32'd0, "R1");
    // R2 readback masks
    wr_reg(3'd0, 32'hFFFF_FFFF); rd_chk(3'd0, 32'h0000_000F, "R2");
    wr_reg(3'd1, 32'hFFFF_FFFF); rd_chk(3'd1, 32'h0000_0004, "R2");
    wr_reg(3'd2, 32'hFFFF_FFFF); rd_chk(3'd2, 32'hFFFF_F000, "R2");
    wr_reg(3'd4, 32'hFFFF_FFFF); rd_chk(3'd4, 32'hFE00_0000, "R2");
    rd_chk(3'd3, 32'd0, "R2");
    wr_reg(3'd0, 32'd0); wr_reg(3'd1, 32'd0);
    // R3 translation off
    xlate(32'hC000_3ABC, "R3", 0);
    wr_reg(3'd2, 32'h0010_0000); wr_reg(3'd4, 32'hC000_0000);
    wr_reg(3'd0, 32'h1); wr_reg(3'd1, 32'h4);
    // R5 walk, R8 hit
    xlate(32'hC000_3ABC, "R5", 0);
    xlate(32'hC000_3123, "R8", 0);
    // R6 directory fault, R7 leaf fault without fill
    xlate(32'hC040_0000, "R6", 0);
    xlate(32'hC000_9000, "R7", 0);
    xlate(32'hC000_9004, "R7", 0);
    // R9 round robin over 4 entries
    xlate(32'hC000_0010, "R9", 0);
    xlate(32'hC000_1010, "R9", 0);
    xlate(32'hC000_2010, "R9", 0);
    xlate(32'hC000_4010, "R9", 0);
    xlate(32'hC000_3000, "R9", 0);
    xlate(32'hC000_1FFF, "R9", 0);
    xlate(32'hC000_0000, "R9", 0);
    // R10 flush
    wr_reg(3'd3, 32'h0000_0002);
    xlate(32'hC000_1000, "R10", 0);
    wr_reg(3'd3, 32'h1);
    rd_chk(3'd3, 32'd0, "R10");
    xlate(32'hC000_1000, "R10", 0);
    // R11 flush mid-walk
    xlate(32'hC000_5000, "R11", 1);
    xlate(32'hC000_5000, "R11", 0);
    xlate(32'hC000_5008, "R11", 0);
    // R4 window sizes
    xlate(32'hC1FF_F000, "R4", 0);
    xlate(32'hC200_0000, "R4", 0);
    wr_reg(3'd0, 32'h7); wr_reg(3'd4, 32'hC000_0000);
    xlate(32'hCFFF_F000, "R4", 0);
    xlate(32'hD000_0000, "R4", 0);
    wr_reg(3'd0, 32'hD); wr_reg(3'd4, 32'h8000_0000);
    xlate(32'hF000_0000, "R4", 0);
    xlate(32'h7FFF_F000, "R4", 0);
    wr_reg(3'd0, 32'hF);
    xlate(32'h8000_0000, "R4", 0);
    xlate(32'h7FFF_FFFC, "R4", 0);
    // R3 each enable alone
    wr_reg(3'd0, 32'h1); wr_reg(3'd4, 32'hC000_0000);
    xlate(32'hC000_5010, "R3", 0);
    wr_reg(3'd1, 32'h0);
    xlate(32'hC000_5010, "R3", 0);
    wr_reg(3'd1, 32'h4); wr_reg(3'd0, 32'h0);
    xlate(32'hC000_5010, "R3", 0);
    check(mon_bad == 0, "R12", $sformatf("%0d per-clock violations expected 0", mon_bad));
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule